// File: doc/BRIEF.md
# Speculative Store Buffer with Ordered Writeback

This block holds stores that have been issued speculatively until the pipeline either commits or discards them. Each store is given a slot when it is allocated, carrying its sequence number and its prefetch and conditional kind. Its address, data and byte count arrive later through an execute request that names that slot. A commit bound marks every buffered store at or below it as allowed to drain. A store-conditional that executes cleanly becomes drainable without waiting for a commit. A squash bound discards the younger stores that have not yet drained.

Drainable stores leave in age order over a set of parallel memory request lanes. Lane 0 always carries the oldest. A lane is offered only when every older lane has been taken, so the lane count is the per-cycle budget. If memory refuses a request, the buffer stops offering anything until a retry pulse arrives, and then starts again with the refused store. Zero-byte and prefetch stores use up a lane position but send nothing. Memory reports each finished write by returning the slot tag. Slots are reclaimed in age order once the oldest one is finished.

The block reports how many stores are drainable but not yet sent, how many are sent but not yet reclaimed, and how many slots may still be allocated.

Top module: `sq_commit_wb`

## Requirements
- R1: After reset no request lane is valid, the drainable and in-flight counts are 0 and `free_slots` equals DEPTH-1.
- R2: `free_slots` equals DEPTH minus the unsent entries minus the in-flight entries minus one reserved slot.
- R3: A commit marks every unsent store with sequence number at or below `commit_seq` as drainable, and `wait_count` rises by the number newly marked.
- R4: An executed store-conditional with `exec_fault` low becomes drainable at once and adds one to `wait_count`; with `exec_fault` high it stays undrainable.
- R5: Drainable stores are offered oldest first, lane 0 being the oldest. Lane k is offered only if lanes below k were all taken, and the offering stops at the first store that is not drainable. At most PORTS stores leave per cycle.
- R6: A drainable store with size 0 or with the prefetch kind leaves the unsent set without any memory request.
- R7: A request presented with `mem_req_ready` low sets a sticky block: no lane is valid until `mem_retry` is pulsed. The first request after the retry is the refused store.
- R8: A squash removes every unsent store whose sequence number is above `squash_seq`, and subtracts from `wait_count` those that were drainable. In a squash cycle, allocate, execute and commit are ignored and no store leaves.
- R9: `mem_done_valid` with a tag marks that slot finished. Finished slots are reclaimed oldest first, one per cycle, and each reclaim lowers `inflight_count` and raises `free_slots`.
- R10: The tag of every request equals the slot index that `alloc_slot` reported when the store was allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_prefetch | input | 1 | New entry is a prefetch |
| alloc_cond | input | 1 | New entry is a store-conditional |
| alloc_slot | output | log2(DEPTH) | Slot the next allocation takes |
| free_slots | output | log2(DEPTH+1) | Allocations still permitted |
| exec_valid | input | 1 | Execute result for a slot |
| exec_slot | input | log2(DEPTH) | Slot being executed |
| exec_addr | input | ADDR_W | Store address |
| exec_data | input | DATA_W | Store data |
| exec_size | input | SIZE_W | Store byte count |
| exec_fault | input | 1 | Execute raised a fault |
| commit_valid | input | 1 | Commit bound is valid |
| commit_seq | input | SEQ_W | Highest committed sequence number |
| squash_valid | input | 1 | Squash bound is valid |
| squash_seq | input | SEQ_W | Stores above this number are discarded |
| mem_req_valid | output | PORTS | Per-lane write request |
| mem_req_ready | input | PORTS | Per-lane acceptance |
| mem_req_addr | output | PORTS x ADDR_W | Per-lane address |
| mem_req_data | output | PORTS x DATA_W | Per-lane data |
| mem_req_size | output | PORTS x SIZE_W | Per-lane byte count |
| mem_req_tag | output | PORTS x log2(DEPTH) | Per-lane slot tag |
| mem_retry | input | 1 | Lifts the block after a refusal |
| mem_done_valid | input | 1 | A sent write has finished |
| mem_done_tag | input | log2(DEPTH) | Slot of the finished write |
| wait_count | output | log2(DEPTH+1) | Drainable stores not yet sent |
| inflight_count | output | log2(DEPTH+1) | Stores sent or skipped and not yet reclaimed |

## Verification
The bench builds the buffer with DEPTH=8 and PORTS=2. With these values a three-store commit must take two cycles to drain, so the lane budget and the lane-0-oldest ordering can be observed directly. The eight slots also make the pointers wrap during the run, so the tail rollback on squash and the in-order reclaim are exercised across the wrap. Narrow 8-bit sequence numbers and 16-bit address and data keep the scoreboard values easy to read.

// File: rtl/sq_pkg.sv
package sq_pkg;
   typedef enum logic [1:0] {
      LANE_STOP = 2'd0,
      LANE_SEND = 2'd1,
      LANE_DROP = 2'd2
   } lane_act_e;
endpackage

// File: rtl/sq_lane_pick.sv
// Chooses which unsent entries leave this cycle, oldest in lane 0.
module sq_lane_pick #(
   parameter int DEPTH = 8,
   parameter int PORTS = 2,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic [PW-1:0]            head,
   input  logic [CW-1:0]            inflight,
   input  logic [CW-1:0]            pend,
   input  logic                     hold,
   input  logic [DEPTH-1:0]         writable,
   input  logic [DEPTH-1:0]         skip,
   input  logic [PORTS-1:0]         ready,
   output logic [PORTS-1:0]         req_valid,
   output logic [PORTS-1:0][PW-1:0] lane_slot,
   output sq_pkg::lane_act_e        lane_act [PORTS],
   output logic [CW-1:0]            pass_cnt,
   output logic                     refused
);
   logic [PORTS-1:0] go;
   logic [PORTS-1:0] take;
   logic [PORTS-1:0] refuse_l;

   assign go[0] = ~hold;

   for (genvar k = 0; k < PORTS; k++) begin : g_lane
      logic [PW-1:0] slot;
      logic          present;
      logic          drop;
      assign slot         = head + inflight[PW-1:0] + PW'(k);
      assign present      = (CW'(k) < pend) && writable[slot];
      assign drop         = present && skip[slot];
      assign req_valid[k] = go[k] && present && !drop;
      assign take[k]      = go[k] && (drop || (present && ready[k]));
      assign refuse_l[k]  = req_valid[k] && !ready[k];
      assign lane_slot[k] = slot;
      assign lane_act[k]  = !take[k] ? sq_pkg::LANE_STOP :
                            (drop ? sq_pkg::LANE_DROP : sq_pkg::LANE_SEND);
      if (k + 1 < PORTS) begin : g_chain
         assign go[k+1] = take[k];
      end
   end

   always_comb begin
      pass_cnt = '0;
      for (int k = 0; k < PORTS; k++) pass_cnt += CW'(take[k]);
   end

   assign refused = |refuse_l;
endmodule

// File: rtl/sq_mark.sv
// Per-slot commit, conditional-execute and squash decisions.
module sq_mark #(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 16,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic [PW-1:0]    head,
   input  logic [CW-1:0]    inflight,
   input  logic [CW-1:0]    pend,
   input  logic [SEQ_W-1:0] seq [DEPTH],
   input  logic [DEPTH-1:0] writable,
   input  logic [DEPTH-1:0] cond,
   input  logic             commit_valid,
   input  logic [SEQ_W-1:0] commit_seq,
   input  logic             exec_valid,
   input  logic [PW-1:0]    exec_slot,
   input  logic             exec_fault,
   input  logic             squash_valid,
   input  logic [SEQ_W-1:0] squash_seq,
   output logic [DEPTH-1:0] set_wb,
   output logic [CW-1:0]    mark_cnt,
   output logic [CW-1:0]    kill_cnt,
   output logic [CW-1:0]    kill_wb_cnt
);
   logic [CW-1:0]    used;
   logic [DEPTH-1:0] kill;

   assign used = inflight + pend;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [PW-1:0] rel;
      logic          unsent;
      logic          commit_hit;
      logic          exec_hit;
      assign rel        = PW'(i) - head;
      assign unsent     = (CW'(rel) < used) && (CW'(rel) >= inflight);
      assign commit_hit = commit_valid && (seq[i] <= commit_seq);
      assign exec_hit   = exec_valid && (exec_slot == PW'(i)) && cond[i] && !exec_fault;
      assign set_wb[i]  = !squash_valid && unsent && !writable[i] && (commit_hit || exec_hit);
      assign kill[i]    = squash_valid && unsent && (seq[i] > squash_seq);
   end

   always_comb begin
      mark_cnt    = '0;
      kill_cnt    = '0;
      kill_wb_cnt = '0;
      for (int i = 0; i < DEPTH; i++) begin
         mark_cnt    += CW'(set_wb[i]);
         kill_cnt    += CW'(kill[i]);
         kill_wb_cnt += CW'(kill[i] && writable[i]);
      end
   end
endmodule

// File: rtl/sq_commit_wb.sv
module sq_commit_wb #(
   parameter int DEPTH  = 8,
   parameter int PORTS  = 2,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SIZE_W = 4,
   parameter int SEQ_W  = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 alloc_valid,
   input  logic [SEQ_W-1:0]                     alloc_seq,
   input  logic                                 alloc_prefetch,
   input  logic                                 alloc_cond,
   output logic [$clog2(DEPTH)-1:0]             alloc_slot,
   output logic [$clog2(DEPTH+1)-1:0]           free_slots,
   input  logic                                 exec_valid,
   input  logic [$clog2(DEPTH)-1:0]             exec_slot,
   input  logic [ADDR_W-1:0]                    exec_addr,
   input  logic [DATA_W-1:0]                    exec_data,
   input  logic [SIZE_W-1:0]                    exec_size,
   input  logic                                 exec_fault,
   input  logic                                 commit_valid,
   input  logic [SEQ_W-1:0]                     commit_seq,
   input  logic                                 squash_valid,
   input  logic [SEQ_W-1:0]                     squash_seq,
   output logic [PORTS-1:0]                     mem_req_valid,
   input  logic [PORTS-1:0]                     mem_req_ready,
   output logic [PORTS-1:0][ADDR_W-1:0]         mem_req_addr,
   output logic [PORTS-1:0][DATA_W-1:0]         mem_req_data,
   output logic [PORTS-1:0][SIZE_W-1:0]         mem_req_size,
   output logic [PORTS-1:0][$clog2(DEPTH)-1:0]  mem_req_tag,
   input  logic                                 mem_retry,
   input  logic                                 mem_done_valid,
   input  logic [$clog2(DEPTH)-1:0]             mem_done_tag,
   output logic [$clog2(DEPTH+1)-1:0]           wait_count,
   output logic [$clog2(DEPTH+1)-1:0]           inflight_count
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sq_commit_wb: DEPTH must be a power of two of at least 2");
   end
   if (PORTS < 1 || PORTS > DEPTH) begin : g_bad_ports
      $error("sq_commit_wb: PORTS must lie between 1 and DEPTH");
   end

   logic [SEQ_W-1:0]  seq_q  [DEPTH];
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [SIZE_W-1:0] size_q [DEPTH];
   logic [DEPTH-1:0]  cwb_q, done_q, pf_q, cond_q, skip;
   logic [PW-1:0]     head_q, tail;
   logic [CW-1:0]     inflight_q, pend_q, wait_q;
   logic              blocked_q;

   logic              alloc_ok, exec_ok, release_fire;
   logic [DEPTH-1:0]  set_wb;
   logic [CW-1:0]     mark_cnt, kill_cnt, kill_wb_cnt, pass_cnt;
   logic              refused;
   logic [PORTS-1:0][PW-1:0] lane_slot;
   sq_pkg::lane_act_e        lane_act [PORTS];

   assign tail         = head_q + inflight_q[PW-1:0] + pend_q[PW-1:0];
   assign alloc_ok     = alloc_valid && !squash_valid;
   assign exec_ok      = exec_valid && !squash_valid;
   assign release_fire = (inflight_q != '0) && done_q[head_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_skip
      assign skip[i] = pf_q[i] || (size_q[i] == '0);
   end

   sq_mark #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_mark (
      .head(head_q), .inflight(inflight_q), .pend(pend_q), .seq(seq_q),
      .writable(cwb_q), .cond(cond_q),
      .commit_valid(commit_valid), .commit_seq(commit_seq),
      .exec_valid(exec_valid), .exec_slot(exec_slot), .exec_fault(exec_fault),
      .squash_valid(squash_valid), .squash_seq(squash_seq),
      .set_wb(set_wb), .mark_cnt(mark_cnt), .kill_cnt(kill_cnt),
      .kill_wb_cnt(kill_wb_cnt)
   );

   sq_lane_pick #(.DEPTH(DEPTH), .PORTS(PORTS)) u_pick (
      .head(head_q), .inflight(inflight_q), .pend(pend_q),
      .hold(blocked_q || squash_valid), .writable(cwb_q), .skip(skip),
      .ready(mem_req_ready), .req_valid(mem_req_valid), .lane_slot(lane_slot),
      .lane_act(lane_act), .pass_cnt(pass_cnt), .refused(refused)
   );

   for (genvar k = 0; k < PORTS; k++) begin : g_req
      assign mem_req_addr[k] = addr_q[lane_slot[k]];
      assign mem_req_data[k] = data_q[lane_slot[k]];
      assign mem_req_size[k] = size_q[lane_slot[k]];
      assign mem_req_tag[k]  = lane_slot[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q     <= '0;
         inflight_q <= '0;
         pend_q     <= '0;
         wait_q     <= '0;
         blocked_q  <= 1'b0;
         cwb_q      <= '0;
         done_q     <= '0;
         pf_q       <= '0;
         cond_q     <= '0;
      end else begin
         cwb_q <= cwb_q | set_wb;
         if (alloc_ok) begin
            cwb_q[tail]  <= 1'b0;
            done_q[tail] <= 1'b0;
            pf_q[tail]   <= alloc_prefetch;
            cond_q[tail] <= alloc_cond;
         end
         for (int k = 0; k < PORTS; k++) begin
            if (lane_act[k] == sq_pkg::LANE_DROP) done_q[lane_slot[k]] <= 1'b1;
         end
         if (mem_done_valid) done_q[mem_done_tag] <= 1'b1;
         head_q     <= head_q + PW'(release_fire);
         inflight_q <= inflight_q + pass_cnt - CW'(release_fire);
         pend_q     <= pend_q + CW'(alloc_ok) - pass_cnt - kill_cnt;
         wait_q     <= wait_q + mark_cnt - pass_cnt - kill_wb_cnt;
         blocked_q  <= blocked_q ? !mem_retry : refused;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_ok) begin
         seq_q[tail]  <= alloc_seq;
         size_q[tail] <= '0;
      end
      if (exec_ok) begin
         addr_q[exec_slot] <= exec_addr;
         data_q[exec_slot] <= exec_data;
         size_q[exec_slot] <= exec_size;
      end
   end

   always_comb begin
      if ((inflight_q + pend_q) >= CW'(DEPTH - 1)) free_slots = '0;
      else free_slots = CW'(DEPTH - 1) - inflight_q - pend_q;
   end

   assign alloc_slot     = tail;
   assign wait_count     = wait_q;
   assign inflight_count = inflight_q;
endmodule

// File: rtl/sq_commit_wb_chk.sv
module sq_commit_wb_chk #(
   parameter int DEPTH = 8,
   parameter int PORTS = 2,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PORTS-1:0] mem_req_valid,
   input logic [PORTS-1:0] mem_req_ready,
   input logic [CW-1:0]    wait_count,
   input logic [CW-1:0]    inflight_count,
   input logic [CW-1:0]    free_slots,
   input logic             squash_valid,
   input logic             mem_done_valid,
   input logic [PW-1:0]    mem_done_tag
);
   p_free_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      free_slots <= CW'(DEPTH - 1));

   p_lane_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mem_req_valid) <= int'(wait_count));

   p_refuse_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mem_req_valid & ~mem_req_ready)) |=> (mem_req_valid == '0));

   p_squash_shrink_r8: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> (wait_count <= $past(wait_count)));

   p_done_has_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_done_valid |-> (inflight_count != '0) && (int'(mem_done_tag) < DEPTH));
endmodule

bind sq_commit_wb sq_commit_wb_chk #(.DEPTH(DEPTH), .PORTS(PORTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .wait_count(wait_count),
   .inflight_count(inflight_count), .free_slots(free_slots),
   .squash_valid(squash_valid), .mem_done_valid(mem_done_valid),
   .mem_done_tag(mem_done_tag)
);

// File: tb/sq_commit_wb_tb_top.sv
module sq_commit_wb_tb_top;
   localparam int DEPTH = 8, PORTS = 2, AW = 16, DW = 16, SW = 4, QW = 8;
   localparam int PW = $clog2(DEPTH), CW = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic                      alloc_valid = 0, alloc_prefetch = 0, alloc_cond = 0;
   logic [QW-1:0]             alloc_seq = '0;
   logic [PW-1:0]             alloc_slot;
   logic [CW-1:0]             free_slots, wait_count, inflight_count;
   logic                      exec_valid = 0, exec_fault = 0;
   logic [PW-1:0]             exec_slot = '0;
   logic [AW-1:0]             exec_addr = '0;
   logic [DW-1:0]             exec_data = '0;
   logic [SW-1:0]             exec_size = '0;
   logic                      commit_valid = 0, squash_valid = 0, mem_retry = 0;
   logic [QW-1:0]             commit_seq = '0, squash_seq = '0;
   logic [PORTS-1:0]          mem_req_valid;
   logic [PORTS-1:0]          mem_req_ready = '1;
   logic [PORTS-1:0][AW-1:0]  mem_req_addr;
   logic [PORTS-1:0][DW-1:0]  mem_req_data;
   logic [PORTS-1:0][SW-1:0]  mem_req_size;
   logic [PORTS-1:0][PW-1:0]  mem_req_tag;
   logic                      mem_done_valid = 0;
   logic [PW-1:0]             mem_done_tag = '0;

   sq_commit_wb #(.DEPTH(DEPTH), .PORTS(PORTS), .ADDR_W(AW), .DATA_W(DW),
                  .SIZE_W(SW), .SEQ_W(QW)) dut_i (.*);

   typedef struct { int addr; int data; int tag; } exp_t;
   exp_t exp_q[$];
   int   tag_q[$];
   int   total = 0, bad = 0, accepts = 0;
   bit   finished = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic expect_req(input int addr, input int data, input int tag);
      exp_t e;
      e.addr = addr; e.data = data; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic do_alloc(input int s, input bit pf, input bit cd, output int slot);
      step();
      alloc_valid = 1; alloc_seq = QW'(s); alloc_prefetch = pf; alloc_cond = cd;
      slot = int'(alloc_slot);
      step();
      alloc_valid = 0; alloc_prefetch = 0; alloc_cond = 0;
   endtask

   task automatic do_exec(input int slot, input int a, input int d, input int sz, input bit f);
      step();
      exec_valid = 1; exec_slot = PW'(slot); exec_addr = AW'(a);
      exec_data = DW'(d); exec_size = SW'(sz); exec_fault = f;
      step();
      exec_valid = 0; exec_fault = 0;
   endtask

   task automatic do_commit(input int s);
      step(); commit_valid = 1; commit_seq = QW'(s);
      step(); commit_valid = 0;
   endtask

   task automatic do_squash(input int s);
      step(); squash_valid = 1; squash_seq = QW'(s);
      step(); squash_valid = 0;
   endtask

   task automatic do_retry();
      step(); mem_retry = 1;
      step(); mem_retry = 0;
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // Scoreboard monitor: every accepted lane must match the oldest expectation (R5, R10).
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < PORTS; k++) begin
            if (mem_req_valid[k] && mem_req_ready[k]) begin
               accepts++;
               tag_q.push_back(int'(mem_req_tag[k]));
               if (exp_q.size() == 0) begin
                  chk("R6 no request expected, lane", k, -1);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk("R5 oldest-first address", int'(mem_req_addr[k]), e.addr);
                  chk("R5 oldest-first data", int'(mem_req_data[k]), e.data);
                  chk("R10 request tag", int'(mem_req_tag[k]), e.tag);
               end
            end
         end
      end
   end

   // Memory responder: finishes accepted writes one per cycle (R9).
   initial begin
      forever begin
         @(posedge clk); #1;
         if (tag_q.size() > 0) begin
            mem_done_valid = 1;
            mem_done_tag = PW'(tag_q.pop_front());
         end else begin
            mem_done_valid = 0;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int sl [64];
      int s;
      settle(3);
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 free after reset", int'(free_slots), DEPTH - 1);
      chk("R1 wait after reset", int'(wait_count), 0);
      chk("R1 inflight after reset", int'(inflight_count), 0);
      chk("R1 no request after reset", int'(mem_req_valid), 0);

      // Phase A: five stores, commit three, lane budget of two
      for (int i = 0; i < 5; i++) begin
         do_alloc(10 + i, 0, 0, s); sl[10 + i] = s;
      end
      chk("R2 free with five unsent", int'(free_slots), 2);
      for (int i = 0; i < 5; i++) do_exec(sl[10 + i], 'h100 + 16 * i, 'hA0 + i, 4, 0);
      for (int i = 0; i < 3; i++) expect_req('h100 + 16 * i, 'hA0 + i, sl[10 + i]);
      do_commit(12);
      chk("R3 commit marks three", int'(wait_count), 3);
      step();
      chk("R5 two lanes per cycle, wait left", int'(wait_count), 1);
      chk("R5 two lanes per cycle, inflight", int'(inflight_count), 2);
      settle(12);
      chk("R9 inflight drained", int'(inflight_count), 0);
      chk("R9 slots reclaimed", int'(free_slots), 5);
      chk("R5 all committed sent", exp_q.size(), 0);

      // Phase B: prefetch and zero-size entries
      do_alloc(15, 1, 0, s); sl[15] = s;
      do_alloc(16, 0, 0, s); sl[16] = s;
      do_exec(sl[13], 'h130, 'hB3, 4, 0);
      do_exec(sl[14], 'h140, 'hB4, 4, 0);
      do_exec(sl[15], 'h150, 'hB5, 4, 0);
      do_exec(sl[16], 'h160, 'hB6, 0, 0);
      expect_req('h130, 'hB3, sl[13]);
      expect_req('h140, 'hB4, sl[14]);
      do_commit(16);
      chk("R3 commit marks four", int'(wait_count), 4);
      settle(14);
      chk("R6 skipped entries leave wait", int'(wait_count), 0);
      chk("R6 only two requests", accepts, 5);
      chk("R9 skipped slots reclaimed", int'(free_slots), DEPTH - 1);

      // Phase C: refusal and retry
      mem_req_ready = '0;
      do_alloc(20, 0, 0, s); sl[20] = s;
      do_exec(sl[20], 'h200, 'hC0, 2, 0);
      expect_req('h200, 'hC0, sl[20]);
      do_commit(20);
      settle(2);
      mem_req_ready = '1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R7 silent while blocked", int'(mem_req_valid), 0);
      end
      chk("R7 store still waiting", int'(wait_count), 1);
      do_retry();
      settle(8);
      chk("R7 refused store resent", exp_q.size(), 0);
      chk("R7 wait cleared after retry", int'(wait_count), 0);

      // Phase D: store-conditional
      do_alloc(30, 0, 1, s); sl[30] = s;
      expect_req('h300, 'hD0, sl[30]);
      do_exec(sl[30], 'h300, 'hD0, 4, 0);
      chk("R4 clean conditional drainable", int'(wait_count), 1);
      settle(6);
      do_alloc(31, 0, 1, s); sl[31] = s;
      do_exec(sl[31], 'h310, 'hD1, 4, 1);
      chk("R4 faulted conditional held", int'(wait_count), 0);
      expect_req('h310, 'hD1, sl[31]);
      do_commit(31);
      settle(10);
      chk("R4 conditionals drained", exp_q.size(), 0);

      // Phase E: squash
      do_alloc(40, 0, 0, s); sl[40] = s;
      do_alloc(41, 0, 0, s); sl[41] = s;
      do_alloc(42, 0, 1, s); sl[42] = s;
      do_exec(sl[40], 'h400, 'hE0, 4, 0);
      do_exec(sl[41], 'h410, 'hE1, 4, 0);
      do_exec(sl[42], 'h420, 'hE2, 4, 0);
      chk("R5 younger drainable waits behind older", int'(wait_count), 1);
      chk("R2 free with three unsent", int'(free_slots), 4);
      do_squash(40);
      chk("R8 squash drops drainable count", int'(wait_count), 0);
      chk("R8 squash frees two", int'(free_slots), 6);
      step();
      squash_valid = 1; squash_seq = QW'(40);
      alloc_valid = 1; alloc_seq = QW'(50);
      step();
      squash_valid = 0; alloc_valid = 0;
      chk("R8 alloc ignored during squash", int'(free_slots), 6);
      expect_req('h400, 'hE0, sl[40]);
      do_commit(40);
      settle(10);
      chk("R9 all reclaimed", int'(free_slots), DEPTH - 1);
      chk("R5 scoreboard empty", exp_q.size(), 0);
      chk("R5 total requests", accepts, 9);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule